// File: doc/BRIEF.md
# Cursor Overlay With Blink

This block draws a small hardware pointer on top of a raster pixel stream. For every pixel the timing logic presents, it works out whether that screen point lies inside a 64 by 64 picture that software has loaded at 2 bits per pixel. It reads the 2-bit code for that point and, when the code is not transparent, replaces the pixel with one of three programmable colours. The picture is placed on the screen by a 16-bit X/Y position. A hotspot offset picks which point inside the picture lines up with that position, so an arrow tip or the centre of a crosshair lands exactly on the pointer coordinate.

Software programs the block through one byte-wide write port. Addresses below 0x400 fill the picture memory, and addresses from 0x400 upward reach the control, position, hotspot, blink and colour registers. New position and hotspot values are held back until the next frame-start strobe, so a move never shows half an old and half a new pointer. The pointer can also blink. A frame counter splits each period of `rate` frames into a visible part and a hidden part, and the duty register sets how large the visible part is.

The downstream mixer takes `cursor_hit` as a select and `cursor_colour` as the replacement pixel, one clock after the raster coordinate is presented.

Top module: `cursor_overlay`

## Requirements
- R1: A write to address 0x000–0x3FF stores one picture byte at index row*16 + col/4. In that byte, pixel col%4 = 0 sits in bits 7:6, 1 in bits 5:4, 2 in bits 3:2 and 3 in bits 1:0.
- R2: The position registers are 0x404 (X bits 7:0), 0x405 (X bits 15:8), 0x406 (Y bits 7:0) and 0x407 (Y bits 15:8). With hotspot (hx,hy), picture pixel (c,r) appears at raster (X−hx+c, Y−hy+r), and no raster point outside that 64×64 window produces a hit.
- R3: Hotspot X is at 0x401 and hotspot Y is at 0x402. Only bits 5:0 of each are used.
- R4: Position and hotspot writes take effect only after the next `frame_start` pulse. Until then, the earlier values stay in force.
- R5: Code 0 is transparent. It gives `cursor_hit` = 0 and `cursor_colour` = 0.
- R6: Codes 1–3 give `cursor_hit` = 1 and the colour entry for that code. Byte k of entry n is written at 0x410 + 4*n + k, with k = 0 going to bits 23:16, k = 1 to bits 15:8 and k = 2 to bits 7:0. Writes to entry 0 are ignored.
- R7: Control register 0x400 bit 0 enables the pointer. While it is 0, no hit is produced.
- R8: While `active_video` is low, no hit is produced.
- R9: Control bit 1 enables blinking, with the rate at 0x408 and the duty at 0x409. A frame counter steps on every `frame_start` pulse and wraps to 0 after rate−1. The pointer shows while count < floor(duty*rate/256). A rate of 0 keeps the pointer always shown.
- R10: Outputs are registered, so a raster coordinate presented in one cycle gives its result after the next rising clock edge. Reset clears the outputs and all registers.
- R11: The window origin X−hx (and likewise Y−hy) is computed without wraparound. When it is negative, only the columns (or rows) that land at raster coordinate 0 or above appear, and raster coordinates near 65535 never hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 11 | Write address: picture memory or registers |
| wr_data | input | 8 | Write data byte |
| raster_x | input | 16 | Current pixel column |
| raster_y | input | 16 | Current pixel line |
| active_video | input | 1 | High while the raster is in the visible area |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cursor_hit | output | 1 | Pointer colour replaces the pixel |
| cursor_colour | output | 24 | Replacement colour, zero when no hit |

## Verification
The bench fills the whole picture memory with random bytes and then probes random raster points in a band slightly wider than the window. These probes separate the correct row and byte addressing, the lane order inside a byte and the edge clipping from off-by-one or reversed-lane mistakes. A directed byte holding codes 0,1,2,3 in its four lanes pins the bit order on its own terms. A second placement, with the hotspot larger than the position, drives the origin negative, and a probe near the top of the coordinate range catches wraparound. Further checks tell the effects apart: moves made before a frame strobe versus after it, active video and the enable bit each turned off alone, and blink sequences at several rate/duty pairs including a rate of zero, compared frame by frame against a counter model.

// File: rtl/curs_pkg.sv
`timescale 1ns/1ps
package curs_pkg;
   localparam int REG_IDX_W = 5;
   localparam logic [REG_IDX_W-1:0] RA_CTRL = 5'h00;
   localparam logic [REG_IDX_W-1:0] RA_HOTX = 5'h01;
   localparam logic [REG_IDX_W-1:0] RA_HOTY = 5'h02;
   localparam logic [REG_IDX_W-1:0] RA_XLO  = 5'h04;
   localparam logic [REG_IDX_W-1:0] RA_XHI  = 5'h05;
   localparam logic [REG_IDX_W-1:0] RA_YLO  = 5'h06;
   localparam logic [REG_IDX_W-1:0] RA_YHI  = 5'h07;
   localparam logic [REG_IDX_W-1:0] RA_RATE = 5'h08;
   localparam logic [REG_IDX_W-1:0] RA_DUTY = 5'h09;

   typedef struct packed {
      logic blink;
      logic show;
   } ctl_t;
endpackage

// File: rtl/curs_regs.sv
`timescale 1ns/1ps
module curs_regs
   import curs_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int HOT_W   = 6,
   parameter int NCODE   = 3,
   parameter int COLOR_W = 24,
   parameter int RATE_W  = 8
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [REG_IDX_W-1:0]     reg_idx,
   input  logic [7:0]               wr_data,
   input  logic                     frame_start,
   output ctl_t                     ctl,
   output logic [HOT_W-1:0]         hot_x,
   output logic [HOT_W-1:0]         hot_y,
   output logic [COORD_W-1:0]       pos_x,
   output logic [COORD_W-1:0]       pos_y,
   output logic [RATE_W-1:0]        rate,
   output logic [RATE_W-1:0]        duty,
   output logic [NCODE*COLOR_W-1:0] pal_flat
);
   localparam int CBYTES = COLOR_W / 8;
   localparam int HI_W   = COORD_W - 8;

   logic [COORD_W-1:0] pend_x, pend_y;
   logic [HOT_W-1:0]   pend_hx, pend_hy;

   // staged registers: written any time, applied at frame start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_x  <= '0;
         pend_y  <= '0;
         pend_hx <= '0;
         pend_hy <= '0;
      end else if (reg_we) begin
         case (reg_idx)
            RA_XLO:  pend_x[7:0]         <= wr_data;
            RA_XHI:  pend_x[COORD_W-1:8] <= wr_data[HI_W-1:0];
            RA_YLO:  pend_y[7:0]         <= wr_data;
            RA_YHI:  pend_y[COORD_W-1:8] <= wr_data[HI_W-1:0];
            RA_HOTX: pend_hx             <= wr_data[HOT_W-1:0];
            RA_HOTY: pend_hy             <= wr_data[HOT_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_x <= '0;
         pos_y <= '0;
         hot_x <= '0;
         hot_y <= '0;
      end else if (frame_start) begin
         pos_x <= pend_x;
         pos_y <= pend_y;
         hot_x <= pend_hx;
         hot_y <= pend_hy;
      end
   end

   // immediate registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl  <= '0;
         rate <= '0;
         duty <= '0;
      end else if (reg_we) begin
         case (reg_idx)
            RA_CTRL: ctl  <= ctl_t'(wr_data[1:0]);
            RA_RATE: rate <= wr_data[RATE_W-1:0];
            RA_DUTY: duty <= wr_data[RATE_W-1:0];
            default: ;
         endcase
      end
   end

   // colour table: entry n at index 0x10 + 4n + byte
   for (genvar c = 1; c <= NCODE; c++) begin : g_ent
      logic [COLOR_W-1:0] ent;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent <= '0;
         end else if (reg_we && reg_idx[4] && (reg_idx[3:2] == 2'(c))) begin
            for (int b = 0; b < CBYTES; b++) begin
               if (reg_idx[1:0] == 2'(b)) ent[COLOR_W-1-8*b -: 8] <= wr_data;
            end
         end
      end
      assign pal_flat[(c-1)*COLOR_W +: COLOR_W] = ent;
   end
endmodule

// File: rtl/curs_pat.sv
`timescale 1ns/1ps
module curs_pat #(
   parameter int PAT_W = 64,
   parameter int PAT_H = 64,
   parameter int BPP   = 2
)(
   input  logic                          clk,
   input  logic                          we,
   input  logic [$clog2(PAT_W*PAT_H*BPP/8)-1:0] waddr,
   input  logic [7:0]                    wdata,
   input  logic [$clog2(PAT_H)-1:0]      row,
   input  logic [$clog2(PAT_W)-1:0]      col,
   output logic [BPP-1:0]                code
);
   localparam int PPB    = 8 / BPP;
   localparam int LANE_W = $clog2(PPB);
   localparam int NBYTES = PAT_W * PAT_H * BPP / 8;
   localparam int COL_W  = $clog2(PAT_W);
   localparam int AW     = $clog2(NBYTES);

   logic [7:0]        mem [NBYTES];
   logic [AW-1:0]     ridx;
   logic [LANE_W-1:0] lane;
   logic [7:0]        rbyte;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign ridx  = {row, col[COL_W-1:LANE_W]};
   assign lane  = col[LANE_W-1:0];
   assign rbyte = mem[ridx];
   // lane 0 occupies the most significant bits of the byte
   assign code  = rbyte[(PPB-1-int'(lane))*BPP +: BPP];
endmodule

// File: rtl/curs_blink.sv
`timescale 1ns/1ps
module curs_blink #(
   parameter int RATE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              blink_on,
   input  logic [RATE_W-1:0] rate,
   input  logic [RATE_W-1:0] duty,
   output logic              visible,
   output logic [RATE_W-1:0] cnt
);
   logic [2*RATE_W-1:0] prod;
   logic [RATE_W:0]     cnt_p1;
   logic [2*RATE_W:0]   thresh;
   logic                wrap;

   assign wrap = (rate == '0) || ({1'b0, cnt} + 1'b1 >= {1'b0, rate});

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (frame_start) cnt <= wrap ? '0 : cnt + 1'b1;
   end

   // shown while cnt < floor(duty*rate / 2^RATE_W), i.e. (cnt+1)<<RATE_W <= product
   assign prod    = duty * rate;
   assign cnt_p1  = {1'b0, cnt} + 1'b1;
   assign thresh  = {cnt_p1, {RATE_W{1'b0}}};
   assign visible = !blink_on || (rate == '0) || (thresh <= {1'b0, prod});
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
   import curs_pkg::*;
#(
   parameter int PAT_W    = 64,
   parameter int PAT_H    = 64,
   parameter int BPP      = 2,
   parameter int COORD_W  = 16,
   parameter int COLOR_W  = 24,
   parameter int RATE_W   = 8,
   parameter bit BLINK_EN = 1'b1,
   localparam int PAT_AW  = $clog2(PAT_W*PAT_H*BPP/8),
   localparam int ADDR_W  = PAT_AW + 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [COORD_W-1:0] raster_x,
   input  logic [COORD_W-1:0] raster_y,
   input  logic               active_video,
   input  logic               frame_start,
   output logic               cursor_hit,
   output logic [COLOR_W-1:0] cursor_colour
);
   localparam int NCODE = (1 << BPP) - 1;
   localparam int HOT_W = $clog2(PAT_W > PAT_H ? PAT_W : PAT_H);
   localparam int COL_W = $clog2(PAT_W);
   localparam int ROW_W = $clog2(PAT_H);
   localparam int DW    = COORD_W + 2;

   // elaboration-time parameter checks
   if (BPP != 1 && BPP != 2) begin : g_bad_bpp
      $error("BPP must be 1 or 2");
   end
   if ((PAT_W & (PAT_W-1)) != 0 || (PAT_H & (PAT_H-1)) != 0) begin : g_bad_dim
      $error("picture dimensions must be powers of two");
   end
   if (PAT_AW < 6) begin : g_bad_aw
      $error("picture memory too small for register window");
   end
   if (COORD_W < 9 || COORD_W > 16) begin : g_bad_coord
      $error("COORD_W must be 9..16");
   end
   if (COLOR_W % 8 != 0 || COLOR_W > 32) begin : g_bad_col
      $error("COLOR_W must be 8, 16, 24 or 32");
   end
   if (RATE_W > 8) begin : g_bad_rate
      $error("RATE_W must fit a byte");
   end

   ctl_t                     ctl;
   logic [HOT_W-1:0]         hot_x, hot_y;
   logic [COORD_W-1:0]       cur_x, cur_y;
   logic [RATE_W-1:0]        rate, duty, blink_cnt;
   logic [NCODE*COLOR_W-1:0] pal_flat;
   logic [COLOR_W-1:0]       pal [NCODE+1];
   logic                     reg_we, pat_we, blink_vis;
   logic signed [DW-1:0]     dx, dy;
   logic                     in_x, in_y;
   logic [BPP-1:0]           pix_code;
   logic                     hit_d;

   // address split: upper half registers (only 0x400..0x41F decode), lower half picture
   assign reg_we = wr_en && wr_addr[ADDR_W-1] && (wr_addr[ADDR_W-2:REG_IDX_W] == '0);
   assign pat_we = wr_en && !wr_addr[ADDR_W-1];

   curs_regs #(
      .COORD_W (COORD_W), .HOT_W (HOT_W), .NCODE (NCODE),
      .COLOR_W (COLOR_W), .RATE_W (RATE_W)
   ) u_regs (
      .clk, .rst_n,
      .reg_we, .reg_idx (wr_addr[REG_IDX_W-1:0]), .wr_data, .frame_start,
      .ctl, .hot_x, .hot_y, .pos_x (cur_x), .pos_y (cur_y),
      .rate, .duty, .pal_flat
   );

   // window test with sign-extended arithmetic: no wraparound
   assign dx = $signed({2'b00, raster_x}) - $signed({2'b00, cur_x})
             + $signed({{(DW-HOT_W){1'b0}}, hot_x});
   assign dy = $signed({2'b00, raster_y}) - $signed({2'b00, cur_y})
             + $signed({{(DW-HOT_W){1'b0}}, hot_y});
   assign in_x = !dx[DW-1] && (dx[DW-2:0] < (DW-1)'(PAT_W));
   assign in_y = !dy[DW-1] && (dy[DW-2:0] < (DW-1)'(PAT_H));

   curs_pat #(.PAT_W (PAT_W), .PAT_H (PAT_H), .BPP (BPP)) u_pat (
      .clk,
      .we    (pat_we),
      .waddr (wr_addr[PAT_AW-1:0]),
      .wdata (wr_data),
      .row   (dy[ROW_W-1:0]),
      .col   (dx[COL_W-1:0]),
      .code  (pix_code)
   );

   if (BLINK_EN) begin : g_blink
      curs_blink #(.RATE_W (RATE_W)) u_blink (
         .clk, .rst_n, .frame_start,
         .blink_on (ctl.blink), .rate, .duty,
         .visible (blink_vis), .cnt (blink_cnt)
      );
   end else begin : g_no_blink
      assign blink_vis = 1'b1;
      assign blink_cnt = '0;
   end

   assign pal[0] = '0;
   for (genvar c = 1; c <= NCODE; c++) begin : g_pal
      assign pal[c] = pal_flat[(c-1)*COLOR_W +: COLOR_W];
   end

   assign hit_d = active_video && ctl.show && blink_vis && in_x && in_y
                && (pix_code != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cursor_hit    <= 1'b0;
         cursor_colour <= '0;
      end else begin
         cursor_hit    <= hit_d;
         cursor_colour <= hit_d ? pal[pix_code] : '0;
      end
   end
endmodule

// File: rtl/cursor_overlay_chk.sv
`timescale 1ns/1ps
module cursor_overlay_chk #(
   parameter int COORD_W = 16,
   parameter int COLOR_W = 24,
   parameter int RATE_W  = 8,
   parameter int BPP     = 2
)(
   input logic               clk,
   input logic               rst_n,
   input logic               active_video,
   input logic               frame_start,
   input logic               cursor_hit,
   input logic [COLOR_W-1:0] cursor_colour,
   input logic               show,
   input logic [BPP-1:0]     code,
   input logic [COORD_W-1:0] cur_x,
   input logic [COORD_W-1:0] cur_y,
   input logic [RATE_W-1:0]  blink_cnt
);
   AST_HIT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cursor_hit |-> $past(active_video)); // R8
   AST_HIT_NEEDS_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
      cursor_hit |-> $past(show)); // R7
   AST_HIT_NEEDS_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
      cursor_hit |-> $past(code != '0)); // R5
   AST_QUIET_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
      !cursor_hit |-> (cursor_colour == '0)); // R5
   AST_POS_X_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> $stable(cur_x)); // R4
   AST_POS_Y_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> $stable(cur_y)); // R4
   AST_BLINK_STEPS_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> $stable(blink_cnt)); // R9
endmodule

bind cursor_overlay cursor_overlay_chk #(
   .COORD_W (COORD_W), .COLOR_W (COLOR_W), .RATE_W (RATE_W), .BPP (BPP)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .active_video  (active_video),
   .frame_start   (frame_start),
   .cursor_hit    (cursor_hit),
   .cursor_colour (cursor_colour),
   .show          (ctl.show),
   .code          (pix_code),
   .cur_x         (cur_x),
   .cur_y         (cur_y),
   .blink_cnt     (blink_cnt)
);

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [10:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] raster_x = '0, raster_y = '0;
   logic        active_video = 1'b0;
   logic        frame_start = 1'b0;
   logic        cursor_hit;
   logic [23:0] cursor_colour;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0]  m_pat [1024];
   logic [23:0] m_pal [4];
   bit          m_en, m_blink;
   int          m_px, m_py, m_hx, m_hy, p_px, p_py, p_hx, p_hy;
   int          m_rate, m_duty, m_cnt;

   cursor_overlay u_cursor_overlay (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .raster_x, .raster_y, .active_video, .frame_start,
      .cursor_hit, .cursor_colour
   );

   always #10 clk = ~clk;

   function automatic logic [24:0] expect_px(int x, int y, bit act);
      int dx = x - m_px + m_hx;
      int dy = y - m_py + m_hy;
      int code;
      bit vis;
      if (!act || !m_en) return '0;
      if (dx < 0 || dx >= 64 || dy < 0 || dy >= 64) return '0;
      code = int'((m_pat[dy*16 + dx/4] >> (6 - 2*(dx%4))) & 8'h3);
      vis  = !m_blink || m_rate == 0 || m_cnt < (m_duty*m_rate)/256;
      if (!vis || code == 0) return '0;
      return {1'b1, m_pal[code]};
   endfunction

   task automatic reg_write(input int addr, input int data);
      wr_en = 1'b1; wr_addr = 11'(addr); wr_data = 8'(data);
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_ctrl(input int v);
      reg_write(11'h400, v); m_en = v[0]; m_blink = v[1];
   endtask
   task automatic set_pos(input int x, input int y);
      reg_write(11'h404, x & 255); reg_write(11'h405, (x >> 8) & 255);
      reg_write(11'h406, y & 255); reg_write(11'h407, (y >> 8) & 255);
      p_px = x; p_py = y;
   endtask
   task automatic set_hot(input int hx, input int hy);
      reg_write(11'h401, hx); reg_write(11'h402, hy);
      p_hx = hx & 63; p_hy = hy & 63;
   endtask
   task automatic set_blink(input int r, input int d);
      reg_write(11'h408, r); reg_write(11'h409, d); m_rate = r; m_duty = d;
   endtask
   task automatic set_pal(input int code, input logic [23:0] rgb);
      for (int k = 0; k < 3; k++) reg_write(11'h410 + 4*code + k, rgb[23-8*k -: 8]);
      if (code != 0) m_pal[code] = rgb;
   endtask
   task automatic pat_write(input int i, input int b);
      reg_write(i, b); m_pat[i] = 8'(b);
   endtask
   task automatic frame();
      active_video = 1'b0; frame_start = 1'b1;
      @(posedge clk); @(negedge clk);
      frame_start = 1'b0;
      m_px = p_px; m_py = p_py; m_hx = p_hx; m_hy = p_hy;
      if (m_rate == 0 || m_cnt >= m_rate - 1) m_cnt = 0; else m_cnt++;
   endtask

   task automatic probe(input int x, input int y, input bit act, input string req);
      logic [24:0] exp_v, got;
      raster_x = 16'(x); raster_y = 16'(y); active_video = act;
      @(posedge clk); @(negedge clk);
      exp_v = expect_px(x, y, act);
      got   = {cursor_hit, cursor_colour};
      checks++;
      if (got !== exp_v) begin
         errors++;
         $display("FAIL %s at (%0d,%0d): got hit=%0b col=%06h expected hit=%0b col=%06h",
                  req, x, y, got[24], got[23:0], exp_v[24], exp_v[23:0]);
      end
   endtask

   task automatic sweep(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         int x = m_px - m_hx + int'($urandom_range(71)) - 4;
         int y = m_py - m_hy + int'($urandom_range(71)) - 4;
         if (x < 0) x = 0;
         if (y < 0) y = 0;
         probe(x, y, 1'b1, req);
      end
   endtask

   initial begin
      void'($urandom(32'h00C0_FFEE));
      m_en = 0; m_blink = 0; m_px = 0; m_py = 0; m_hx = 0; m_hy = 0;
      p_px = 0; p_py = 0; p_hx = 0; p_hy = 0; m_rate = 0; m_duty = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) m_pal[i] = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      checks++;
      if (cursor_hit !== 1'b0 || cursor_colour !== 24'h0) begin
         errors++;
         $display("FAIL R10 reset: got hit=%0b col=%06h expected hit=0 col=000000",
                  cursor_hit, cursor_colour);
      end
      rst_n = 1'b1;
      @(negedge clk);
      probe(0, 0, 1'b1, "R10");

      // R1: fill picture with random bytes
      for (int i = 0; i < 1024; i++) pat_write(i, int'($urandom_range(255)));
      set_pal(1, 24'h11_22_33);
      set_pal(2, 24'hA0_B1_C2);
      set_pal(3, 24'hFE_01_7C);
      set_pal(0, 24'hDE_AD_99);  // R6: entry 0 ignored
      set_ctrl(1);
      set_pos(100, 50); set_hot(0, 0);
      frame();
      // R1 directed: row 5, bytes with lanes 0..3 holding codes 0,1,2,3
      pat_write(5*16 + 2, 8'h1B);
      for (int c = 0; c < 4; c++) probe(100 + 8 + c, 55, 1'b1, "R1");
      // R2 R6 R5: random probes around the window
      sweep(200, "R2/R5/R6");

      // R4: staged move, not yet applied
      set_pos(700, 400); set_hot(5, 7);
      sweep(40, "R4 before frame");
      frame();
      sweep(120, "R3/R4 after frame");
      // R3: upper hotspot bits ignored
      set_hot(8'hC0 | 3, 8'h40 | 9);
      frame();
      sweep(60, "R3");

      // R11: negative origin and no wraparound
      set_pos(2, 3); set_hot(10, 12);
      frame();
      for (int i = 0; i < 80; i++)
         probe(int'($urandom_range(60)), int'($urandom_range(58)), 1'b1, "R11");
      probe(65534, 0, 1'b1, "R11 wrap");
      probe(65530, 65533, 1'b1, "R11 wrap");

      // R8: active video low
      set_pos(300, 200); set_hot(0, 0);
      frame();
      for (int i = 0; i < 20; i++)
         probe(300 + int'($urandom_range(63)), 200 + int'($urandom_range(63)), 1'b0, "R8");
      // R7: display disabled
      set_ctrl(0);
      for (int i = 0; i < 20; i++)
         probe(300 + int'($urandom_range(63)), 200 + int'($urandom_range(63)), 1'b1, "R7");

      // R9: blink with a known opaque pixel at picture (0,0)
      pat_write(0, 8'hC0);
      set_ctrl(3);
      set_blink(4, 128);
      for (int f = 0; f < 10; f++) begin frame(); probe(300, 200, 1'b1, "R9 4/128"); end
      set_blink(3, 255);
      for (int f = 0; f < 8; f++) begin frame(); probe(300, 200, 1'b1, "R9 3/255"); end
      set_blink(5, 40);
      for (int f = 0; f < 8; f++) begin frame(); probe(300, 200, 1'b1, "R9 5/40"); end
      set_blink(0, 0);
      for (int f = 0; f < 3; f++) begin frame(); probe(300, 200, 1'b1, "R9 rate0"); end
      set_blink(4, 0);
      set_ctrl(1);  // blink off: always shown
      for (int f = 0; f < 4; f++) begin frame(); probe(300, 200, 1'b1, "R9 off"); end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule